// File: doc/BRIEF.md
# Reloadable Baud Tick Generator

This block turns the system clock into timing strobes for an asynchronous serial core. A fixed prescaler divides the clock by two, or by three if selected. A down-counter loaded from a reload register then stretches each prescaler pulse train into one sample tick. The sample tick runs at sixteen times the bit rate. Every sixteenth sample tick also raises a bit tick.

To get a bit rate `baud` with the divide-by-two prescaler, software programs the reload value as `(clk / (16 * baud)) / 2 - 1`. The safe sequence is to drop run, write the reload value, and raise run again. A reload write made while running is still well defined: the period in progress finishes with the old value. The fractional-divider enable is an integer-only interlock. While it is high the generator behaves as stopped.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, `sample_tick` and `bit_tick` are low and the stored reload value is 0.
- R2: With `pre_sel` = 0, `run` = 1 and `frac_en` = 0, consecutive `sample_tick` pulses are 2*(reload+1) clock cycles apart.
- R3: With `pre_sel` = 1, consecutive `sample_tick` pulses are 3*(reload+1) clock cycles apart.
- R4: When `run` is first sampled high, the first `sample_tick` is high in the cycle that follows the P*(reload+1)-th rising edge at which run is sampled high. P is 2 or 3, chosen by `pre_sel`.
- R5: Each `sample_tick` and `bit_tick` pulse lasts exactly one clock cycle.
- R6: `bit_tick` rises together with every sixteenth `sample_tick`, counted from the start of a run. It is never high without `sample_tick`.
- R7: While `run` is low, no ticks are produced, and the prescaler, counter and sample count are held. A later start behaves as in R4.
- R8: While `frac_en` is high, the block behaves exactly as if `run` were low.
- R9: A reload value written with `reload_we` while running is not used by the period in progress. It takes effect from the next counter reload.
- R10: A reload value of 0 gives a `sample_tick` every P cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Generator run control |
| pre_sel | input | 1 | Prescaler select: 0 divides by 2, 1 divides by 3 |
| frac_en | input | 1 | Fractional-divider enable; must be low for ticks |
| reload_we | input | 1 | Write strobe for the reload register |
| reload_in | input | RW | Reload value to store |
| sample_tick | output | 1 | One-cycle oversampling tick |
| bit_tick | output | 1 | One-cycle bit-period tick |

## Verification
Both ticks come from one output register. A tick therefore appears in the cycle after the rising edge on which the prescaler and the counter both reach their terminal counts. For a fresh start, that edge is the P*(reload+1)-th edge after run is seen high. A change to `run` or `frac_en` silences the outputs from the next cycle onward. A reload write changes only the period that starts after the next terminal count. The bench updates a cycle model on each rising edge from the inputs it drove half a cycle earlier. It compares both outputs on the falling edge, so each expected pulse is checked in exactly the cycle it is due.

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int RW  = 16,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          pre_sel,
  input  logic          frac_en,
  input  logic          reload_we,
  input  logic [RW-1:0] reload_in,
  output logic          sample_tick,
  output logic          bit_tick
);
  localparam int SW = $clog2(OVS);
  localparam logic [SW-1:0] SUB_LAST = SW'(OVS - 1);

  logic [RW-1:0] reload_q;
  logic [RW-1:0] cnt;
  logic [1:0]    pc;
  logic [SW-1:0] sub;
  logic          st_q, bt_q;

  wire active  = run & ~frac_en;
  wire pc_last = (pc == (pre_sel ? 2'd2 : 2'd1));
  wire wrap    = active & pc_last & (cnt == '0);

  assign sample_tick = st_q;
  assign bit_tick    = bt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt      <= '0;
      pc       <= '0;
      sub      <= '0;
      st_q     <= 1'b0;
      bt_q     <= 1'b0;
    end else begin
      if (reload_we) reload_q <= reload_in;
      st_q <= wrap;
      bt_q <= wrap & (sub == SUB_LAST);
      if (!active) begin
        pc  <= '0;
        cnt <= reload_q;
        sub <= '0;
      end else begin
        pc <= pc_last ? 2'd0 : pc + 2'd1;
        if (pc_last) cnt <= (cnt == '0) ? reload_q : cnt - 1'b1;
        if (wrap) sub <= (sub == SUB_LAST) ? '0 : sub + 1'b1;
      end
    end
  end

  p_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> !sample_tick);

  p_bit_with_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);

  p_stop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!sample_tick && !bit_tick));

  p_frac_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frac_en |=> (!sample_tick && !bit_tick));
endmodule

// File: tb/baud_tick_gen_tb_top.sv
module baud_tick_gen_tb_top;
  localparam int RW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, pre_sel = 1'b0, frac_en = 1'b0, reload_we = 1'b0;
  logic [RW-1:0] reload_in = '0;
  logic sample_tick, bit_tick;

  int checks = 0, fails = 0;
  string tag = "R1";
  bit checking = 1'b0;

  int ph = 0, cur = 0, sc = 0, mrel = 0;
  bit es = 1'b0, eb = 1'b0;

  always #2 clk = ~clk;

  baud_tick_gen #(.RW(RW), .OVS(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .pre_sel(pre_sel), .frac_en(frac_en),
    .reload_we(reload_we), .reload_in(reload_in),
    .sample_tick(sample_tick), .bit_tick(bit_tick));

  // expected-value model, advanced on each rising edge from requirement R2..R10
  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; cur = 0; sc = 0; es = 0; eb = 0; mrel = 0;
    end else begin
      if (!(run && !frac_en)) begin
        ph = 0; cur = mrel; sc = 0; es = 0; eb = 0;
      end else begin
        ph++;
        if (ph == (pre_sel ? 3 : 2) * (cur + 1)) begin
          es = 1; eb = (sc == 15); sc = (sc + 1) % 16; ph = 0; cur = mrel;
        end else begin
          es = 0; eb = 0;
        end
      end
      if (reload_we) mrel = int'(reload_in);
    end
  end

  function automatic int period(input bit ps, input int r);
    return (ps ? 3 : 2) * (r + 1);
  endfunction

  task automatic check(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && checking) begin
      check(tag, "sample_tick", int'(sample_tick), int'(es));
      check(tag, "bit_tick", int'(bit_tick), int'(eb));
    end
  end

  task automatic stop_and_load(input int r, input bit ps);
    @(negedge clk); run = 0;
    @(negedge clk); reload_we = 1; reload_in = RW'(r); pre_sel = ps;
    @(negedge clk); reload_we = 0;
    @(negedge clk);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n, first;
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    check("R1", "sample_tick in reset", int'(sample_tick), 0);
    check("R1", "bit_tick in reset", int'(bit_tick), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", "sample_tick after reset", int'(sample_tick), 0);
    checking = 1;

    // R4: first tick latency, reload 3, divide by 2
    tag = "R4";
    stop_and_load(3, 0);
    run = 1; n = 0; first = -1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); n++;
      if (sample_tick && first < 0) first = n;
    end
    check("R4", "first tick cycle", first, period(0, 3));

    tag = "R2"; cycles(600);
    tag = "R3"; stop_and_load(5, 1); run = 1; cycles(2000);
    tag = "R10"; stop_and_load(0, 0); run = 1; cycles(300);
    tag = "R10"; stop_and_load(0, 1); run = 1; cycles(300);

    // R7: stop mid-run, then restart
    tag = "R7"; stop_and_load(2, 0); run = 1; cycles(17);
    run = 0; cycles(20); run = 1; cycles(200);

    // R8: frac_en blocks ticks
    tag = "R8"; frac_en = 1; cycles(30); frac_en = 0; cycles(100);

    // R9: reload write while running
    tag = "R9"; stop_and_load(7, 0); run = 1; cycles(5);
    reload_we = 1; reload_in = RW'(1);
    @(negedge clk); reload_we = 0; cycles(200);

    // mixed random segments
    for (int s = 0; s < 40; s++) begin
      tag = (s % 2) ? "R3" : "R2";
      stop_and_load(int'($urandom_range(0, 20)), bit'(s % 2));
      run = 1;
      n = int'($urandom_range(50, 600));
      for (int i = 0; i < n; i++) begin
        @(negedge clk);
        if ($urandom_range(0, 199) == 0) begin
          tag = "R9"; reload_we = 1; reload_in = RW'($urandom_range(0, 20));
        end else reload_we = 0;
        if ($urandom_range(0, 299) == 0) begin tag = "R8"; frac_en = 1; end
        else frac_en = 0;
      end
      reload_we = 0; frac_en = 0;
    end

    tag = "R6"; stop_and_load(1, 0); run = 1; cycles(400);
    run = 0; cycles(4);
    checking = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule